// File: doc/BRIEF.md
# DQS Rising-Edge Search Engine

This block trains the strobe timing of a memory interface one byte lane at a time, all lanes in parallel. Starting from a delay that software or an earlier training step supplies, it finds for every lane the delay at which the sampled strobe status turns from 0 to 1. It presents a per-lane delay on its outputs and asks an outside memory-test agent for a status read. Each read returns a word with one bit per lane. Repeated reads are reduced to one sample per lane by majority vote.

A search starts with a coarse probe. Three samples are taken at fixed offsets from the start delays, and each lane's 3-bit result picks a new start point and a search direction. A fine loop then moves every lane that has not yet reached its edge by one phase-interpolator step per iteration, all lanes in lock-step. The loop stops in the first iteration in which no lane moves. The block then pulses done. It shows the final delays both as absolute values and split into a half-clock coarse count, a fine code and deadband controls. It aborts with an error flag when a delay leaves the encodable range or when the search does not settle.

Top module: `dqs_edge_search`

## Requirements
- R1: After start, the first three votes are taken with each lane's applied delay equal to its start delay plus 0, plus STEP_PI (26) and plus twice STEP_PI (52), in that order. The first vote forms the most significant bit of the lane's 3-bit pattern.
- R2: The pattern selects the fine start delay and direction for each lane. 000 and 100 add 2·STEP_PI and search forward. 001 and 101 add STEP_PI and search forward. 010 and 011 add nothing and search forward. 110 and 111 add nothing and search backward.
- R3: In each fine iteration, every active lane is voted at once. A forward lane that votes 0 gains 1, and a backward lane that votes 1 loses 1. The search completes in the first iteration in which no lane moved, so a forward lane ends on the first delay that reads 1 and a backward lane ends one below the lowest delay that reads 1.
- R4: One vote uses VOTE_N status reads (default 5). The lane votes 1 only when more than half of those reads carried a 1 for it, so a minority of disagreeing reads does not change the outcome.
- R5: The status word holds one 16-bit field per pair of lanes, with field g at bits 16g+15..16g. In read-enable mode (mode_wr = 0), lane 2g reads bit 16g+1 and lane 2g+1 reads bit 16g+0. In write-strobe mode (mode_wr = 1), they read bits 16g+9 and 16g+8. All other bits have no effect.
- R6: Each lane's delay is shown as a 4-bit coarse count of 64-step half clocks and a 6-bit fine code, with value = 64·coarse + fine. Above 1023 the coarse count saturates at 15 and the fine code carries the low 6 bits of the excess over 960.
- R7: The deadband enable of a lane is 1 when its fine code is below EARLY_TH (10) or above LATE_TH (54). The deadband +1 select is 1 only when the fine code is below EARLY_TH.
- R8: With half_width = 1, only the lower two lanes are searched. The upper lanes keep their start delays unchanged through the whole run.
- R9: When a new delay of an active lane would exceed 1023, including a backward step below 0, the search stops. done pulses and err_range is 1.
- R10: When the fine loop has moved a lane in MAX_ITER (256) successive iterations without settling, the search stops after that 256th step. done pulses, err_timeout is 1 and err_range is 0.
- R11: sample_req stays high, and lane_dly stays unchanged, until status_valid is seen with it. sample_req is low in the done cycle. done lasts exactly one cycle, and the error flags hold until the next start.
- R12: After reset, sample_req, done, err_range and err_timeout are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search while idle |
| mode_wr | input | 1 | 0: read-enable status bits, 1: write-strobe status bits |
| half_width | input | 1 | Search only the lower half of the lanes |
| init_dly | input | NUM_LANES*DLY_W | Start delay per lane, lane 0 in the low bits |
| sample_req | output | 1 | Status read requested at the applied delays |
| lane_dly | output | NUM_LANES*DLY_W | Delay applied per lane; final delay after done |
| status_valid | input | 1 | Status word is valid; completes one read |
| status_word | input | NUM_LANES*8 | Per-lane status bits, 16 bits per lane pair |
| done | output | 1 | One-cycle pulse when the search ends |
| err_range | output | 1 | A delay left the encodable range |
| err_timeout | output | 1 | The fine loop did not settle |
| coarse_out | output | NUM_LANES*4 | Half-clock count per lane |
| fine_out | output | NUM_LANES*6 | Fine code per lane |
| db_en | output | NUM_LANES | Deadband enable per lane |
| db_sel | output | NUM_LANES | Deadband +1 select per lane |

## Verification
The bench uses the default parameters: four lanes, 11-bit delays, a 5-read vote, a 26-step probe offset, thresholds of 10 and 54, and a 256-iteration limit. With 11-bit delays, a backward step below zero wraps above 1023, so underflow is caught by the same range check as overflow. With the 5-read vote, two inverted reads per vote leave the majority intact. The status model is a 128-step periodic strobe with a per-lane edge, which produces the plain patterns (001, 011) as well as the duty-cycle patterns (100, 110) from one set of start values. A constant-zero model keeps every lane moving long enough to reach the 256-step timeout within a few thousand cycles.

// File: rtl/dqs_search_pkg.sv
package dqs_search_pkg;

    localparam int HALF_PI = 64;
    localparam int CRS_W   = 4;
    localparam int FINE_W  = 6;
    localparam int DLY_MAX = (2 ** CRS_W) * HALF_PI - 1;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COARSE,
        S_FINE
    } srch_state_e;

    // {backward, probe-step multiple} chosen from a 3-bit probe pattern
    function automatic logic [2:0] pick_start(input logic [2:0] pat);
        logic [2:0] r;
        case (pat)
            3'b000, 3'b100: r = 3'b0_10;
            3'b001, 3'b101: r = 3'b0_01;
            3'b010, 3'b011: r = 3'b0_00;
            default:        r = 3'b1_00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dqs_vote.sv
module dqs_vote #(
    parameter int VOTE_N = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic take,
    input  logic last,
    input  logic bit_in,
    output logic vote
);
    localparam int CW = $clog2(VOTE_N + 1);

    logic [CW-1:0] ones_d, ones_q;
    logic [CW+1:0] total;

    always_comb begin
        total  = {2'b00, ones_q} + {{(CW+1){1'b0}}, bit_in};
        vote   = (total << 1) > (CW+2)'(VOTE_N);
        ones_d = ones_q;
        if (clr || (take && last)) begin
            ones_d = '0;
        end else if (take) begin
            ones_d = total[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ones_q <= '0;
        else        ones_q <= ones_d;
    end
endmodule

// File: rtl/dqs_dly_split.sv
module dqs_dly_split
    import dqs_search_pkg::*;
#(
    parameter int DLY_W    = 11,
    parameter int EARLY_TH = 10,
    parameter int LATE_TH  = 54
) (
    input  logic [DLY_W-1:0]  dly,
    output logic [CRS_W-1:0]  coarse,
    output logic [FINE_W-1:0] fine,
    output logic              db_en,
    output logic              db_sel
);
    logic [DLY_W-1:0] rem;

    always_comb begin
        if (dly > DLY_W'(DLY_MAX)) coarse = '1;
        else                       coarse = dly[CRS_W+FINE_W-1:FINE_W];
        rem    = dly - (DLY_W'(coarse) << FINE_W);
        fine   = rem[FINE_W-1:0];
        db_sel = fine < FINE_W'(EARLY_TH);
        db_en  = db_sel || (fine > FINE_W'(LATE_TH));
    end
endmodule

// File: rtl/dqs_edge_search.sv
module dqs_edge_search
    import dqs_search_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int DLY_W     = 11,
    parameter int VOTE_N    = 5,
    parameter int STEP_PI   = 26,
    parameter int EARLY_TH  = 10,
    parameter int LATE_TH   = 54,
    parameter int MAX_ITER  = 256,
    parameter int GRP_W     = 16,
    parameter int RD_BIT    = 1,
    parameter int WR_BIT    = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        mode_wr,
    input  logic                        half_width,
    input  logic [NUM_LANES*DLY_W-1:0]  init_dly,
    output logic                        sample_req,
    output logic [NUM_LANES*DLY_W-1:0]  lane_dly,
    input  logic                        status_valid,
    input  logic [NUM_LANES*8-1:0]      status_word,
    output logic                        done,
    output logic                        err_range,
    output logic                        err_timeout,
    output logic [NUM_LANES*CRS_W-1:0]  coarse_out,
    output logic [NUM_LANES*FINE_W-1:0] fine_out,
    output logic [NUM_LANES-1:0]        db_en,
    output logic [NUM_LANES-1:0]        db_sel
);
    localparam int CW     = $clog2(VOTE_N + 1);
    localparam int ITER_W = $clog2(MAX_ITER) + 1;
    localparam int HALF_L = NUM_LANES / 2;

    typedef struct packed {
        srch_state_e                       st;
        logic [1:0]                        k;
        logic [CW-1:0]                     vcnt;
        logic [ITER_W-1:0]                 iter;
        logic [NUM_LANES-1:0][DLY_W-1:0]   dly;
        logic [NUM_LANES-1:0][2:0]         pat;
        logic [NUM_LANES-1:0]              bwd;
        logic [NUM_LANES-1:0]              act;
        logic                              wmode;
        logic                              done;
        logic                              erng;
        logic                              etmo;
    } srch_t;

    srch_t s_d, s_q;

    logic                  take, last, vclr;
    logic [NUM_LANES-1:0]  lane_bit, vote;
    logic [DLY_W-1:0]      probe_ofs;

    assign sample_req = (s_q.st == S_COARSE) || (s_q.st == S_FINE);
    assign take       = sample_req && status_valid;
    assign last       = s_q.vcnt == CW'(VOTE_N - 1);
    assign vclr       = (s_q.st == S_IDLE) && start;
    assign probe_ofs  = (s_q.st == S_COARSE) ? DLY_W'(s_q.k) * DLY_W'(STEP_PI) : '0;

    assign done        = s_q.done;
    assign err_range   = s_q.erng;
    assign err_timeout = s_q.etmo;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        localparam int RB = GRP_W * (l / 2) + RD_BIT - (l % 2);
        localparam int WB = GRP_W * (l / 2) + WR_BIT - (l % 2);

        assign lane_bit[l] = s_q.wmode ? status_word[WB] : status_word[RB];
        assign lane_dly[l*DLY_W +: DLY_W] = s_q.dly[l] + probe_ofs;

        dqs_vote #(.VOTE_N(VOTE_N)) u_vote (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (vclr),
            .take   (take),
            .last   (last),
            .bit_in (lane_bit[l]),
            .vote   (vote[l])
        );

        dqs_dly_split #(.DLY_W(DLY_W), .EARLY_TH(EARLY_TH), .LATE_TH(LATE_TH)) u_split (
            .dly    (s_q.dly[l]),
            .coarse (coarse_out[l*CRS_W +: CRS_W]),
            .fine   (fine_out[l*FINE_W +: FINE_W]),
            .db_en  (db_en[l]),
            .db_sel (db_sel[l])
        );
    end

    always_comb begin
        logic [DLY_W-1:0] nd;
        logic [2:0]       np;
        logic [2:0]       pick;
        logic             moved;
        logic             over;

        s_d      = s_q;
        s_d.done = 1'b0;
        moved    = 1'b0;
        over     = 1'b0;
        nd       = '0;
        np       = '0;
        pick     = '0;

        case (s_q.st)
            S_IDLE: begin
                if (start) begin
                    s_d.st    = S_COARSE;
                    s_d.k     = '0;
                    s_d.vcnt  = '0;
                    s_d.iter  = '0;
                    s_d.wmode = mode_wr;
                    s_d.act   = half_width ? {{(NUM_LANES-HALF_L){1'b0}}, {HALF_L{1'b1}}} : '1;
                    s_d.erng  = 1'b0;
                    s_d.etmo  = 1'b0;
                    for (int l = 0; l < NUM_LANES; l++) begin
                        s_d.dly[l] = init_dly[l*DLY_W +: DLY_W];
                        s_d.pat[l] = '0;
                        s_d.bwd[l] = 1'b0;
                    end
                end
            end
            S_COARSE: begin
                if (take) begin
                    if (!last) begin
                        s_d.vcnt = s_q.vcnt + 1'b1;
                    end else begin
                        s_d.vcnt = '0;
                        for (int l = 0; l < NUM_LANES; l++) begin
                            np         = {s_q.pat[l][1:0], vote[l]};
                            s_d.pat[l] = np;
                            if (s_q.k == 2'd2 && s_q.act[l]) begin
                                pick       = pick_start(np);
                                nd         = s_q.dly[l] + DLY_W'(pick[1:0]) * DLY_W'(STEP_PI);
                                s_d.dly[l] = nd;
                                s_d.bwd[l] = pick[2];
                                if (nd > DLY_W'(DLY_MAX)) over = 1'b1;
                            end
                        end
                        if (s_q.k != 2'd2) begin
                            s_d.k = s_q.k + 1'b1;
                        end else if (over) begin
                            s_d.st   = S_IDLE;
                            s_d.erng = 1'b1;
                            s_d.done = 1'b1;
                        end else begin
                            s_d.st = S_FINE;
                        end
                    end
                end
            end
            S_FINE: begin
                if (take) begin
                    if (!last) begin
                        s_d.vcnt = s_q.vcnt + 1'b1;
                    end else begin
                        s_d.vcnt = '0;
                        for (int l = 0; l < NUM_LANES; l++) begin
                            nd = s_q.dly[l];
                            if (s_q.act[l] && !s_q.bwd[l] && !vote[l]) begin
                                nd    = s_q.dly[l] + 1'b1;
                                moved = 1'b1;
                            end else if (s_q.act[l] && s_q.bwd[l] && vote[l]) begin
                                nd    = s_q.dly[l] - 1'b1;
                                moved = 1'b1;
                            end
                            s_d.dly[l] = nd;
                            if (s_q.act[l] && nd > DLY_W'(DLY_MAX)) over = 1'b1;
                        end
                        if (over) begin
                            s_d.st   = S_IDLE;
                            s_d.erng = 1'b1;
                            s_d.done = 1'b1;
                        end else if (!moved) begin
                            s_d.st   = S_IDLE;
                            s_d.done = 1'b1;
                        end else if (s_q.iter == ITER_W'(MAX_ITER - 1)) begin
                            s_d.st   = S_IDLE;
                            s_d.etmo = 1'b1;
                            s_d.done = 1'b1;
                        end else begin
                            s_d.iter = s_q.iter + 1'b1;
                        end
                    end
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dqs_edge_search_chk.sv
module dqs_edge_search_chk #(
    parameter int DW = 44
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_req,
    input logic          status_valid,
    input logic [DW-1:0] lane_dly,
    input logic          done,
    input logic          err_range,
    input logic          err_timeout
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req && !status_valid |=> sample_req); // R11

    AST_DLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req && !status_valid |=> $stable(lane_dly)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sample_req); // R11

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(err_range && err_timeout)); // R10

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_req && !done |=> $stable(err_range) || sample_req); // R9
endmodule

bind dqs_edge_search dqs_edge_search_chk #(.DW(NUM_LANES*DLY_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_req   (sample_req),
    .status_valid (status_valid),
    .lane_dly     (lane_dly),
    .done         (done),
    .err_range    (err_range),
    .err_timeout  (err_timeout)
);

// File: tb/test_dqs_edge_search.sv
module test_dqs_edge_search;
    localparam int NL = 4;
    localparam int DW = 11;
    localparam int SW = NL * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              mode_wr = 1'b0;
    logic              half_width = 1'b0;
    logic [NL*DW-1:0]  init_dly = '0;
    logic              sample_req;
    logic [NL*DW-1:0]  lane_dly;
    logic              status_valid = 1'b0;
    logic [SW-1:0]     status_word = '0;
    logic              done, err_range, err_timeout;
    logic [NL*4-1:0]   coarse_out;
    logic [NL*6-1:0]   fine_out;
    logic [NL-1:0]     db_en, db_sel;

    int checks = 0;
    int errors = 0;
    int init_d[NL];
    int edge_e[NL];
    int kind[NL];      // 0 periodic strobe, 1 constant 0, 2 constant 1
    bit noise = 0;
    int rd_cnt = 0;
    int probe[3][NL];

    always #2 clk = ~clk;

    dqs_edge_search #(
        .NUM_LANES(NL), .DLY_W(DW), .VOTE_N(5), .STEP_PI(26),
        .EARLY_TH(10), .LATE_TH(54), .MAX_ITER(256)
    ) i_dqs_edge_search (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_wr(mode_wr),
        .half_width(half_width), .init_dly(init_dly), .sample_req(sample_req),
        .lane_dly(lane_dly), .status_valid(status_valid), .status_word(status_word),
        .done(done), .err_range(err_range), .err_timeout(err_timeout),
        .coarse_out(coarse_out), .fine_out(fine_out), .db_en(db_en), .db_sel(db_sel)
    );

    function automatic bit mbit(int l, int d);
        int m;
        case (kind[l])
            0: begin
                m = (((d - edge_e[l]) % 128) + 128) % 128;
                return m < 64;
            end
            1: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // Reference search per the requirements, one lane at a time
    function automatic int exp_final(int l);
        int p = 0;
        int d;
        bit bk;
        for (int k = 0; k < 3; k++) p = (p << 1) | int'(mbit(l, init_d[l] + 26 * k));
        case (p)
            0, 4: begin d = init_d[l] + 52; bk = 0; end
            1, 5: begin d = init_d[l] + 26; bk = 0; end
            2, 3: begin d = init_d[l];      bk = 0; end
            default: begin d = init_d[l];   bk = 1; end
        endcase
        for (int i = 0; i < 400; i++) begin
            if (!bk && !mbit(l, d))     d = d + 1;
            else if (bk && mbit(l, d))  d = d - 1;
            else break;
        end
        return d;
    endfunction

    // Status responder: answers each request one cycle later, drives at negedge
    always @(negedge clk) begin
        logic [SW-1:0] w;
        int d, pos, alt;
        bit b;
        if (sample_req && !status_valid) begin
            w = '0;
            for (int l = 0; l < NL; l++) begin
                d = int'(lane_dly[l*DW +: DW]);
                if (rd_cnt % 5 == 0 && rd_cnt / 5 < 3) probe[rd_cnt/5][l] = d;
                b = mbit(l, d);
                if (noise && (rd_cnt % 5) < 2) b = !b;
                pos = 16 * (l / 2) + (mode_wr ? 9 : 1) - (l % 2);
                alt = 16 * (l / 2) + (mode_wr ? 1 : 9) - (l % 2);
                w[pos] = b;
                w[alt] = !b;
            end
            status_word  = w;
            status_valid = 1'b1;
            rd_cnt++;
        end else begin
            status_valid = 1'b0;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(bit wm, bit hw);
        int n = 0;
        for (int l = 0; l < NL; l++) init_dly[l*DW +: DW] = DW'(init_d[l]);
        mode_wr    = wm;
        half_width = hw;
        rd_cnt     = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R11", "done seen before watchdog", int'(done), 1);
    endtask

    task automatic chk_lane(int l, int e, string req);
        int c, f;
        c = (e > 1023) ? 15 : e / 64;
        f = (e - c * 64) % 64;
        chk(int'(lane_dly[l*DW +: DW]) == e, req, $sformatf("lane%0d delay", l),
            int'(lane_dly[l*DW +: DW]), e);
        chk(int'(coarse_out[l*4 +: 4]) == c, "R6", $sformatf("lane%0d coarse", l),
            int'(coarse_out[l*4 +: 4]), c);
        chk(int'(fine_out[l*6 +: 6]) == f, "R6", $sformatf("lane%0d fine", l),
            int'(fine_out[l*6 +: 6]), f);
        chk(db_en[l] == (f < 10 || f > 54), "R7", $sformatf("lane%0d db_en", l),
            int'(db_en[l]), int'(f < 10 || f > 54));
        chk(db_sel[l] == (f < 10), "R7", $sformatf("lane%0d db_sel", l),
            int'(db_sel[l]), int'(f < 10));
    endtask

    task automatic chk_ok_run(bit hw, string req);
        chk(err_range == 1'b0, "R9", "no range error", int'(err_range), 0);
        chk(err_timeout == 1'b0, "R10", "no timeout", int'(err_timeout), 0);
        for (int l = 0; l < NL; l++)
            chk_lane(l, (hw && l >= 2) ? init_d[l] : exp_final(l), req);
    endtask

    task automatic t_reset;
        chk(sample_req == 0, "R12", "sample_req after reset", int'(sample_req), 0);
        chk(done == 0, "R12", "done after reset", int'(done), 0);
        chk(err_range == 0 && err_timeout == 0, "R12", "errors after reset",
            int'({err_range, err_timeout}), 0);
    endtask

    // Patterns 100, 001, 011, 110 across the four lanes (R2, R3)
    task automatic t_rcv_full;
        init_d = '{100, 300, 500, 50};
        edge_e = '{170, 330, 505, 20};
        kind   = '{0, 0, 0, 0};
        noise  = 0;
        run(1'b0, 1'b0);
        chk_ok_run(1'b0, "R2 R3");
        for (int k = 0; k < 3; k++)
            for (int l = 0; l < NL; l++)
                chk(probe[k][l] == init_d[l] + 26 * k, "R1", $sformatf("probe %0d lane%0d", k, l),
                    probe[k][l], init_d[l] + 26 * k);
        @(negedge clk);
        chk(done == 0, "R11", "done is one cycle", int'(done), 0);
        chk(sample_req == 0, "R11", "idle after done", int'(sample_req), 0);
    endtask

    // Write-strobe bit positions, opposite-mode bits inverted (R5)
    task automatic t_wr_full;
        init_d = '{0, 64, 640, 900};
        edge_e = '{60, 100, 700, 960};
        kind   = '{0, 0, 0, 0};
        noise  = 0;
        run(1'b1, 1'b0);
        chk_ok_run(1'b0, "R5");
    endtask

    // Upper lanes would move forward if searched (R8)
    task automatic t_half;
        init_d = '{200, 210, 5, 5};
        edge_e = '{230, 190, 0, 0};
        kind   = '{0, 0, 1, 1};
        noise  = 0;
        run(1'b0, 1'b1);
        chk_ok_run(1'b1, "R8");
    endtask

    // Two of five reads inverted per vote (R4)
    task automatic t_noise;
        init_d = '{100, 300, 500, 50};
        edge_e = '{170, 330, 505, 20};
        kind   = '{0, 0, 0, 0};
        noise  = 1;
        run(1'b0, 1'b0);
        chk_ok_run(1'b0, "R4");
        noise  = 0;
    endtask

    // Constant 0 forever: 52 + 256 steps then abort (R10)
    task automatic t_timeout;
        init_d = '{0, 0, 0, 0};
        kind   = '{1, 1, 1, 1};
        run(1'b0, 1'b0);
        chk(err_timeout == 1, "R10", "timeout flag", int'(err_timeout), 1);
        chk(err_range == 0, "R10", "no range flag", int'(err_range), 0);
        for (int l = 0; l < NL; l++)
            chk(int'(lane_dly[l*DW +: DW]) == 308, "R10", $sformatf("lane%0d stop delay", l),
                int'(lane_dly[l*DW +: DW]), 308);
    endtask

    // Coarse start 1000 + 52 exceeds range (R9, R6 saturation)
    task automatic t_over;
        init_d = '{1000, 0, 0, 0};
        kind   = '{1, 1, 1, 1};
        run(1'b0, 1'b0);
        chk(err_range == 1, "R9", "overflow flag", int'(err_range), 1);
        chk(err_timeout == 0, "R9", "no timeout", int'(err_timeout), 0);
        chk(int'(coarse_out[3:0]) == 15, "R6", "saturated coarse", int'(coarse_out[3:0]), 15);
        chk(int'(fine_out[5:0]) == 28, "R6", "fine past saturation", int'(fine_out[5:0]), 28);
    endtask

    // Backward step below zero (R9)
    task automatic t_under;
        init_d = '{0, 0, 0, 0};
        kind   = '{2, 2, 2, 2};
        run(1'b0, 1'b0);
        chk(err_range == 1, "R9", "underflow flag", int'(err_range), 1);
        @(negedge clk);
        chk(err_range == 1, "R11", "error flag held", int'(err_range), 1);
    endtask

    initial begin
        kind = '{0, 0, 0, 0};
        edge_e = '{0, 0, 0, 0};
        init_d = '{0, 0, 0, 0};
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rcv_full();
        t_wr_full();
        t_half();
        t_noise();
        t_timeout();
        t_over();
        t_under();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL R11 watchdog expired: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule